// File: doc/BRIEF.md
# GPIO Pin Event Detector

This block watches a vector of already polarity-corrected GPIO input bits and turns selected activity on each pin into a sticky event status bit. Each pin can be configured for one of three triggers: a high level, a rising edge, or any change (both edges). A single interrupt line combines the status bits with a per-pin enable mask.

The block keeps a registered copy of the input vector, refreshed on every clock, and finds edges by comparing the live inputs against that copy. Status bits are set on the clock edge that follows the triggering input. They stay set until software clears them with a write-one-to-clear strobe. If a clear and a new event hit the same bit in the same cycle, the new event wins.

The surrounding register decoder supplies the configuration masks and the clear strobe. The pin-resolution logic supplies the input vector. Changing the configuration masks never produces an edge by itself, because edges are taken only from the input vector.

Top module: `gpio_evt_unit`

## Requirements
- R1: When reset is asserted, the status vector and the interrupt are zero and the previous-input copy is zero. As a result, a pin in rising-edge mode that is already high when reset is released sets its status bit on the first clock after release.
- R2: A pin whose type bit is 0 (level mode) sets its status bit on every clock edge at which its input bit is 1.
- R3: A pin whose type bit is 1 and whose both-edges bit is 0 (rising mode) sets its status bit only when its input goes from 0 at the previous clock to 1 at the current clock. A 1-to-0 change does not set the bit.
- R4: A pin whose type bit is 1 and whose both-edges bit is 1 sets its status bit on any change of its input between consecutive clocks.
- R5: Status bits are sticky. A set bit stays 1 until a clock edge at which the clear strobe is high and the matching bit of the clear mask is 1. Clear-mask bits that are 0 leave their status bits unchanged.
- R6: If a clear and a new event target the same bit at the same clock edge, the bit ends up 1.
- R7: The interrupt output is 1 exactly when some bit of (status AND enable) is 1. It follows a change of the enable mask in the same cycle.
- R8: Changing the type, both-edges or enable masks while the inputs are held steady sets no status bit in edge modes.
- R9: The previous-input copy is refreshed on every clock. An input held high in rising mode, once its status is cleared, does not set the bit again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | NPINS | Polarity-corrected input data |
| evt_type_i | input | NPINS | Per-pin type: 0 level, 1 edge |
| evt_both_i | input | NPINS | Per-pin both-edges select (edge mode only) |
| evt_en_i | input | NPINS | Per-pin interrupt enable |
| sts_clr_we_i | input | 1 | Write-one-to-clear strobe for status |
| sts_clr_i | input | NPINS | Clear mask, 1 clears the bit |
| evt_sts_o | output | NPINS | Sticky event status |
| irq_o | output | 1 | Interrupt request |

## Verification
A status bit is due one clock after the input sample that triggers it, or one clock after the clear that removes it. The interrupt is combinational on status and enable, so it changes in the same cycle as either of them. The bench drives stimulus on the falling edge. A behavioural model updates on the rising edge, and the outputs are compared a quarter period after each rising edge, before any new stimulus arrives. Directed checks read the outputs at the following falling edge, which is one full register stage after the inputs were applied.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  typedef enum logic [1:0] {
    EVT_LEVEL = 2'd0,
    EVT_RISE  = 2'd1,
    EVT_BOTH  = 2'd2
  } evt_mode_e;

  function automatic evt_mode_e pin_mode(input logic typ, input logic both);
    if (!typ)     return EVT_LEVEL;
    else if (both) return EVT_BOTH;
    else           return EVT_RISE;
  endfunction

endpackage

// File: rtl/gpio_evt_prev.sv
module gpio_evt_prev #(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] din_i,
  output logic [NPINS-1:0] prev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= '0;
    else         prev_o <= din_i;
  end
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] cur_i,
  input  logic [NPINS-1:0] prev_i,
  input  logic [NPINS-1:0] type_i,
  input  logic [NPINS-1:0] both_i,
  output logic [NPINS-1:0] hit_o
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    evt_mode_e mode;
    logic      hit_b;
    assign mode = pin_mode(type_i[p], both_i[p]);
    always_comb begin
      case (mode)
        EVT_LEVEL: hit_b = cur_i[p];
        EVT_RISE:  hit_b = cur_i[p] & ~prev_i[p];
        default:   hit_b = cur_i[p] ^ prev_i[p];
      endcase
    end
    assign hit_o[p] = hit_b;
  end
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] set_i,
  input  logic             clr_we_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] sts_o
);
  logic [NPINS-1:0] clr_eff;
  logic [NPINS-1:0] sts_d;

  assign clr_eff = clr_we_i ? clr_i : '0;
  // set has priority over clear
  assign sts_d   = (sts_o & ~clr_eff) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_o <= '0;
    else         sts_o <= sts_d;
  end

  // R5
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(sts_o) & ~sts_o) & ~$past(clr_eff)) == '0));

  // R6
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((sts_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] sts_i,
  input  logic [NPINS-1:0] en_i,
  output logic             irq_o
);
  assign irq_o = |(sts_i & en_i);
endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit #(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] din_i,
  input  logic [NPINS-1:0] evt_type_i,
  input  logic [NPINS-1:0] evt_both_i,
  input  logic [NPINS-1:0] evt_en_i,
  input  logic             sts_clr_we_i,
  input  logic [NPINS-1:0] sts_clr_i,
  output logic [NPINS-1:0] evt_sts_o,
  output logic             irq_o
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] hit;

  gpio_evt_prev #(.NPINS(NPINS)) u_prev (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (din_i),
    .prev_o (prev_q)
  );

  gpio_evt_detect #(.NPINS(NPINS)) u_detect (
    .cur_i  (din_i),
    .prev_i (prev_q),
    .type_i (evt_type_i),
    .both_i (evt_both_i),
    .hit_o  (hit)
  );

  gpio_evt_status #(.NPINS(NPINS)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (hit),
    .clr_we_i (sts_clr_we_i),
    .clr_i    (sts_clr_i),
    .sts_o    (evt_sts_o)
  );

  gpio_evt_irq #(.NPINS(NPINS)) u_irq (
    .sts_i (evt_sts_o),
    .en_i  (evt_en_i),
    .irq_o (irq_o)
  );

  // R2
  level_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((din_i & ~evt_type_i) != '0) |=>
      ((evt_sts_o & $past(din_i & ~evt_type_i)) == $past(din_i & ~evt_type_i)));

  // R7
  irq_needs_sts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((evt_sts_o & evt_en_i) != '0));

  // R7
  no_en_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_en_i == '0) |-> !irq_o);

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (evt_sts_o == '0 && !irq_o));
endmodule

// File: tb/gpio_evt_unit_bench.sv
module gpio_evt_unit_bench;
  localparam int N = 32;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] din = '0, typ = '0, both = '0, en = '0, clr = '0;
  logic         clr_we = 1'b0;
  logic [N-1:0] sts;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_evt_unit #(.NPINS(N)) u_gpio_evt_unit (
    .clk_i(clk), .rst_ni(rst_n), .din_i(din), .evt_type_i(typ),
    .evt_both_i(both), .evt_en_i(en), .sts_clr_we_i(clr_we),
    .sts_clr_i(clr), .evt_sts_o(sts), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [N-1:0] m_sts, m_prev;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sts  <= '0;
      m_prev <= '0;
    end else begin
      logic [N-1:0] nxt;
      nxt = m_sts;
      for (int i = 0; i < N; i++) begin
        if (clr_we && clr[i]) nxt[i] = 1'b0;
        if (!typ[i]) begin
          if (din[i]) nxt[i] = 1'b1;
        end else if (din[i] != m_prev[i]) begin
          if (both[i] || din[i]) nxt[i] = 1'b1;
        end
      end
      m_sts  <= nxt;
      m_prev <= din;
    end
  end

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      chk("R5 model status", sts, m_sts);
      chk("R7 model irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |(m_sts & en)});
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear(input logic [N-1:0] m);
    clr_we = 1'b1; clr = m;
    tick();
    clr_we = 1'b0; clr = '0;
  endtask

  initial begin
    repeat (3) tick();
    chk("R1 reset status", sts, '0);
    chk("R1 reset irq", {31'b0, irq}, '0);
    rst_n = 1'b1;
    tick();
    chk("R1 idle after reset", sts, '0);

    // level mode
    din = 32'h5; en = 32'h4;
    tick();
    chk("R2 level sets", sts, 32'h5);
    chk("R7 irq with enable", {31'b0, irq}, 32'h1);
    clear(32'h5);
    chk("R6 set wins over clear", sts, 32'h5);
    din = '0;
    tick();
    chk("R5 held after input drops", sts, 32'h5);
    clear(32'h5);
    chk("R5 cleared", sts, '0);
    chk("R7 irq low after clear", {31'b0, irq}, '0);

    // sticky with partial clear
    din = 32'h1; tick(); din = '0; tick(); tick();
    chk("R5 sticky", sts, 32'h1);
    clear(32'h2);
    chk("R5 zero mask bit keeps status", sts, 32'h1);
    chk("R7 irq off for non-enabled bit", {31'b0, irq}, '0);
    clear(32'h1);
    chk("R5 one mask bit clears", sts, '0);

    // rising mode
    typ = '1; both = '0;
    din = 32'h8; tick();
    chk("R3 rising sets", sts, 32'h8);
    clear(32'h8);
    chk("R9 held high no re-set", sts, '0);
    din = '0; tick();
    chk("R3 falling ignored", sts, '0);

    // both edges
    both = 32'h10;
    din = 32'h10; tick();
    chk("R4 rise sets", sts, 32'h10);
    clear(32'h10);
    chk("R4 cleared", sts, '0);
    din = '0; tick();
    chk("R4 fall sets", sts, 32'h10);
    clear(32'h10);

    // configuration changes create no edge
    din = 32'h40; tick(); clear(32'h40);
    chk("R8 setup cleared", sts, '0);
    both = 32'h40; tick();
    chk("R8 both toggle no event", sts, '0);
    both = '0; tick();
    chk("R8 both restore no event", sts, '0);
    en = '1; tick();
    chk("R8 enable change no event", sts, '0);
    chk("R7 no irq without status", {31'b0, irq}, '0);
    en = 32'h4;

    // reset with input already high in rising mode
    din = 32'h80;
    rst_n = 1'b0;
    tick();
    chk("R1 status zero in reset", sts, '0);
    rst_n = 1'b1;
    tick();
    chk("R1 prev copy reset gives edge", sts, 32'h80);
    tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule